// File: doc/BRIEF.md
# Keyed Read-Sequence Save/Restore Trigger

This block watches the cycle stream on a memory's 13-bit address bus and looks for a fixed run of six reads. The first five reads must hit a set of key addresses in a fixed order. The sixth read then picks the action. One tail address starts a save of the array into nonvolatile cells. The other tail address starts a restore from those cells. Write cycles and unexpected read addresses break the run. The block does not look at the output-enable level.

Once an action is accepted, the block gives a one-cycle request pulse and raises a chip-disable level. That level stays high for the whole modelled duration, which is a parameter counted in clock cycles. A restore runs in two phases, clear and then transfer, and each phase has its own indicator. A low-voltage inhibit input blocks saves but not restores. A busy input holds the detector idle and discards any progress made so far. The array, the nonvolatile transfer and analog timing lie outside this block.

Top module: `seqcmd_unlock`

## Requirements
- R1: A sixth read launches an action only after five accepted reads at 0x0000, 0x1555, 0x0AAA, 0x1FFF and 0x10F0, in that order, with no other accepted cycle between them.
- R2: A sixth read at 0x0F0F produces `store_req` high for exactly one cycle, in the cycle after the clock edge that samples that read. `recall_req` stays low.
- R3: A sixth read at 0x0F0E produces `recall_req` high for exactly one cycle, in the cycle after the sampling edge. Any other sixth address launches nothing.
- R4: A write cycle (`cyc_valid`=1, `cyc_is_read`=0) at any point discards the progress made so far.
- R5: A read at an address other than the expected one discards the progress. If that address is 0x0000, it counts as the first step of a new run.
- R6: The level of `oe_lvl` has no effect on detection.
- R7: After a launch, `chip_off` is high for exactly STORE_CYC cycles for a save, or CLR_CYC+XFER_CYC cycles for a restore, starting in the pulse cycle. Cycles presented while `chip_off` is high are ignored.
- R8: While `lv_inhibit` is high at the sixth read, a save is suppressed: no pulse and no `chip_off`. A restore is not suppressed.
- R9: A restore asserts `clr_phase` for CLR_CYC cycles and then, in the next cycle, `xfer_phase` for XFER_CYC cycles. The two are never high together.
- R10: A cycle presented while `busy_in` is high is ignored, and any progress made before it is discarded.
- R11: Reset drives all outputs low and discards any partial run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_valid | input | 1 | An access cycle is present this clock |
| cyc_is_read | input | 1 | 1 = read cycle, 0 = write cycle |
| oe_lvl | input | 1 | Output-enable level (not used for detection) |
| addr | input | ADDR_W | Cycle address |
| lv_inhibit | input | 1 | Low-voltage inhibit for saves |
| busy_in | input | 1 | External busy; freezes and clears the detector |
| store_req | output | 1 | One-cycle save launch pulse |
| recall_req | output | 1 | One-cycle restore launch pulse |
| chip_off | output | 1 | Array access disabled while an action runs |
| clr_phase | output | 1 | Restore clear phase active |
| xfer_phase | output | 1 | Restore transfer phase active |

## Verification
The assertions assume that every input is settled at each rising edge and that `addr` is a defined value whenever `cyc_valid` is high. They also assume that reset is held for at least one edge before the first cycle. The bench drives all inputs on the falling edge and checks the outputs one time unit after the rising edge. It lowers `cyc_valid` between scenarios and waits for `chip_off` to fall before it starts a new run, except where it deliberately sends reads into the disabled window.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

   localparam int unsigned KEY_W     = 13;
   localparam int unsigned KEY_STEPS = 5;

   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_SAVE  = 2'd1,
      OP_CLEAR = 2'd2,
      OP_XFER  = 2'd3
   } op_state_t;

   localparam logic [KEY_W-1:0] SAVE_TAIL    = 13'h0F0F;
   localparam logic [KEY_W-1:0] RESTORE_TAIL = 13'h0F0E;

   function automatic logic [KEY_W-1:0] key_at(input logic [2:0] idx);
      case (idx)
         3'd0:    key_at = 13'h0000;
         3'd1:    key_at = 13'h1555;
         3'd2:    key_at = 13'h0AAA;
         3'd3:    key_at = 13'h1FFF;
         3'd4:    key_at = 13'h10F0;
         default: key_at = 13'h0000;
      endcase
   endfunction

endpackage

// File: rtl/seq_key_matcher.sv
module seq_key_matcher
   import seqcmd_pkg::*;
#(
   parameter int unsigned ADDR_W           = 13,
   parameter bit          RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              acc,
   input  logic              is_read,
   input  logic [ADDR_W-1:0] addr,
   input  logic              inhibit,
   output logic              launch_save,
   output logic              launch_restore
);

   localparam int unsigned HI_W = ADDR_W - KEY_W;

   logic [2:0]       step_q, step_d, restart_step;
   logic [KEY_W-1:0] low_addr;
   logic             hi_zero, hit_key, is_first, tail_save, tail_rest;

   assign low_addr = addr[KEY_W-1:0];

   if (HI_W == 0) begin : g_no_hi
      assign hi_zero = 1'b1;
   end else begin : g_hi
      assign hi_zero = (addr[ADDR_W-1:KEY_W] == '0);
   end

   always_comb begin
      hit_key   = hi_zero && (step_q < 3'(KEY_STEPS)) && (low_addr == key_at(step_q));
      is_first  = hi_zero && (low_addr == key_at(3'd0));
      tail_save = hi_zero && (step_q == 3'(KEY_STEPS)) && (low_addr == SAVE_TAIL);
      tail_rest = hi_zero && (step_q == 3'(KEY_STEPS)) && (low_addr == RESTORE_TAIL);
   end

   if (RESTART_ON_FIRST) begin : g_restart_first
      assign restart_step = is_first ? 3'd1 : 3'd0;
   end else begin : g_restart_zero
      assign restart_step = 3'd0;
   end

   always_comb begin
      launch_save    = !flush && acc && is_read && tail_save && !inhibit;
      launch_restore = !flush && acc && is_read && tail_rest;
      if (flush)                       step_d = 3'd0;
      else if (!acc)                   step_d = step_q;
      else if (!is_read)               step_d = 3'd0;
      else if (hit_key)                step_d = step_q + 3'd1;
      else if (tail_save || tail_rest) step_d = 3'd0;
      else                             step_d = restart_step;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= 3'd0;
      else        step_q <= step_d;
   end

   // R4: an accepted write always discards progress
   p_write_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !is_read) |=> (step_q == 3'd0));

   // R10: flush leaves the detector at step zero
   p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (step_q == 3'd0));

   p_step_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= 3'(KEY_STEPS));

endmodule

// File: rtl/op_sequencer.sv
module op_sequencer
   import seqcmd_pkg::*;
#(
   parameter int unsigned SAVE_CYC = 64,
   parameter int unsigned CLR_CYC  = 8,
   parameter int unsigned XFER_CYC = 32
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_save,
   input  logic go_restore,
   output logic save_pulse,
   output logic restore_pulse,
   output logic busy_off,
   output logic clr_on,
   output logic xfer_on
);

   localparam int unsigned MAX_CYC = (SAVE_CYC > CLR_CYC)
                                     ? ((SAVE_CYC > XFER_CYC) ? SAVE_CYC : XFER_CYC)
                                     : ((CLR_CYC > XFER_CYC) ? CLR_CYC : XFER_CYC);
   localparam int unsigned CNT_W = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

   op_state_t        st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q          <= OP_IDLE;
         cnt_q         <= '0;
         save_pulse    <= 1'b0;
         restore_pulse <= 1'b0;
      end else begin
         save_pulse    <= 1'b0;
         restore_pulse <= 1'b0;
         case (st_q)
            OP_IDLE: begin
               if (go_save) begin
                  st_q       <= OP_SAVE;
                  cnt_q      <= CNT_W'(SAVE_CYC - 1);
                  save_pulse <= 1'b1;
               end else if (go_restore) begin
                  st_q          <= OP_CLEAR;
                  cnt_q         <= CNT_W'(CLR_CYC - 1);
                  restore_pulse <= 1'b1;
               end
            end
            OP_SAVE: begin
               if (cnt_q == '0) st_q <= OP_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
            OP_CLEAR: begin
               if (cnt_q == '0) begin
                  st_q  <= OP_XFER;
                  cnt_q <= CNT_W'(XFER_CYC - 1);
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            default: begin
               if (cnt_q == '0) st_q <= OP_IDLE;
               else             cnt_q <= cnt_q - 1'b1;
            end
         endcase
      end
   end

   assign busy_off = (st_q != OP_IDLE);
   assign clr_on   = (st_q == OP_CLEAR);
   assign xfer_on  = (st_q == OP_XFER);

   p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      save_pulse |=> !save_pulse);

   p_pulse_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      restore_pulse |=> !restore_pulse);

   p_pulse_disables_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (save_pulse || restore_pulse) |-> busy_off);

   p_phase_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_on && xfer_on));

   p_clear_then_xfer_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(clr_on) |-> xfer_on);

   p_restore_starts_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      restore_pulse |-> clr_on);

endmodule

// File: rtl/seqcmd_unlock.sv
module seqcmd_unlock #(
   parameter int unsigned ADDR_W           = 13,
   parameter int unsigned STORE_CYC        = 64,
   parameter int unsigned CLR_CYC          = 8,
   parameter int unsigned XFER_CYC         = 32,
   parameter bit          RESTART_ON_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cyc_valid,
   input  logic              cyc_is_read,
   input  logic              oe_lvl,
   input  logic [ADDR_W-1:0] addr,
   input  logic              lv_inhibit,
   input  logic              busy_in,
   output logic              store_req,
   output logic              recall_req,
   output logic              chip_off,
   output logic              clr_phase,
   output logic              xfer_phase
);

   if (ADDR_W < 13) begin : g_bad_addr_w
      $error("seqcmd_unlock: ADDR_W must be at least 13");
   end
   if (STORE_CYC < 1 || CLR_CYC < 1 || XFER_CYC < 1) begin : g_bad_cyc
      $error("seqcmd_unlock: every duration must be at least one cycle");
   end

   logic flush, go_save, go_restore;

   assign flush = chip_off || busy_in;

   seq_key_matcher #(
      .ADDR_W          (ADDR_W),
      .RESTART_ON_FIRST(RESTART_ON_FIRST)
   ) matcher_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .flush         (flush),
      .acc           (cyc_valid),
      .is_read       (cyc_is_read),
      .addr          (addr),
      .inhibit       (lv_inhibit),
      .launch_save   (go_save),
      .launch_restore(go_restore)
   );

   op_sequencer #(
      .SAVE_CYC(STORE_CYC),
      .CLR_CYC (CLR_CYC),
      .XFER_CYC(XFER_CYC)
   ) seq_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .go_save      (go_save),
      .go_restore   (go_restore),
      .save_pulse   (store_req),
      .restore_pulse(recall_req),
      .busy_off     (chip_off),
      .clr_on       (clr_phase),
      .xfer_on      (xfer_phase)
   );

   // R8: a save pulse never follows an inhibited sixth read
   p_inhibit_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      store_req |-> $past(!lv_inhibit));

   // R7: no new launch while the previous action still holds the chip off
   p_no_relaunch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(chip_off) |-> !(store_req || recall_req));

   // R10: a busy cycle cannot be the launching read
   p_busy_no_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |-> $past(!busy_in));

   // R1/R6: a launch follows a valid read, at either output-enable level
   p_launch_from_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (store_req || recall_req) |->
         $past(cyc_valid && cyc_is_read && (oe_lvl || !oe_lvl)));

   p_req_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({store_req, recall_req}));

endmodule

// File: tb/seqcmd_unlock_tb_top.sv
module seqcmd_unlock_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int ST_CYC = 8;
   localparam int CL_CYC = 3;
   localparam int XF_CYC = 4;
   localparam int NVEC   = 20;

   // entry: {write, oe, addr[12:0], exp_store, exp_recall}
   localparam logic [16:0] VEC [NVEC] = '{
      {1'b0, 1'b1, 13'h0000, 2'b00},
      {1'b0, 1'b1, 13'h1555, 2'b00},
      {1'b1, 1'b1, 13'h0AAA, 2'b00},
      {1'b0, 1'b1, 13'h1FFF, 2'b00},
      {1'b0, 1'b1, 13'h10F0, 2'b00},
      {1'b0, 1'b1, 13'h0F0F, 2'b00},
      {1'b0, 1'b1, 13'h0000, 2'b00},
      {1'b0, 1'b1, 13'h1555, 2'b00},
      {1'b0, 1'b1, 13'h0AAA, 2'b00},
      {1'b0, 1'b1, 13'h1FFF, 2'b00},
      {1'b0, 1'b1, 13'h10F0, 2'b00},
      {1'b0, 1'b1, 13'h0F0D, 2'b00},
      {1'b0, 1'b0, 13'h0000, 2'b00},
      {1'b0, 1'b0, 13'h1555, 2'b00},
      {1'b0, 1'b0, 13'h0000, 2'b00},
      {1'b0, 1'b0, 13'h1555, 2'b00},
      {1'b0, 1'b0, 13'h0AAA, 2'b00},
      {1'b0, 1'b0, 13'h1FFF, 2'b00},
      {1'b0, 1'b0, 13'h10F0, 2'b00},
      {1'b0, 1'b0, 13'h0F0E, 2'b01}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cyc_valid = 1'b0, cyc_is_read = 1'b1, oe_lvl = 1'b1;
   logic [12:0] addr = '0;
   logic        lv_inhibit = 1'b0, busy_in = 1'b0;
   logic        store_req, recall_req, chip_off, clr_phase, xfer_phase;

   int total = 0;
   int bad = 0;
   int n_off, n_clr, n_xfer, n_st, n_rc, n_order;

   always #(CLK_PERIOD/2) clk = ~clk;

   seqcmd_unlock #(
      .ADDR_W   (13),
      .STORE_CYC(ST_CYC),
      .CLR_CYC  (CL_CYC),
      .XFER_CYC (XF_CYC)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .cyc_valid(cyc_valid), .cyc_is_read(cyc_is_read),
      .oe_lvl(oe_lvl), .addr(addr), .lv_inhibit(lv_inhibit), .busy_in(busy_in),
      .store_req(store_req), .recall_req(recall_req), .chip_off(chip_off),
      .clr_phase(clr_phase), .xfer_phase(xfer_phase)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (chip_off)   n_off++;
         if (store_req)  n_st++;
         if (recall_req) n_rc++;
         if (xfer_phase && n_clr != CL_CYC) n_order++;
         if (clr_phase && n_xfer != 0) n_order++;
         if (clr_phase)  n_clr++;
         if (xfer_phase) n_xfer++;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic mon_clear();
      n_off = 0; n_clr = 0; n_xfer = 0; n_st = 0; n_rc = 0; n_order = 0;
   endtask

   task automatic cyc(input bit wr, input bit oe, input logic [12:0] a);
      @(negedge clk);
      cyc_valid = 1'b1; cyc_is_read = !wr; oe_lvl = oe; addr = a;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         cyc_valid = 1'b0;
      end
   endtask

   task automatic seq6(input logic [12:0] tail);
      cyc(0, 1, 13'h0000); cyc(0, 1, 13'h1555); cyc(0, 1, 13'h0AAA);
      cyc(0, 1, 13'h1FFF); cyc(0, 1, 13'h10F0); cyc(0, 1, tail);
      @(posedge clk); #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      mon_clear();
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk({store_req, recall_req, chip_off, clr_phase, xfer_phase} == 5'b0, "R11 reset outputs",
          {store_req, recall_req, chip_off, clr_phase, xfer_phase}, 0);
      @(negedge clk); rst_n = 1'b1;

      // table walk: R4 write break, R3 wrong tail, R5 restart on 0x0000, R6 oe low
      for (int i = 0; i < NVEC; i++) begin
         cyc(VEC[i][16], VEC[i][15], VEC[i][14:2]);
         @(posedge clk); #1;
         chk({store_req, recall_req} == VEC[i][1:0],
             (i < 6) ? "R4 write breaks" : (i < 12) ? "R3 wrong tail" : "R5/R6 restart oe-low",
             {store_req, recall_req}, VEC[i][1:0]);
      end
      idle(20);

      // R2 and R7: save pulse, duration, reads ignored while off
      mon_clear();
      seq6(13'h0F0F);
      chk(store_req && !recall_req && chip_off, "R2 store pulse", {store_req, recall_req, chip_off}, 3'b101);
      cyc(0, 1, 13'h0000); cyc(0, 1, 13'h1555); cyc(0, 1, 13'h0AAA);
      cyc(0, 1, 13'h1FFF); cyc(0, 1, 13'h10F0); cyc(0, 1, 13'h0F0E);
      idle(20);
      chk(n_st == 1, "R2 single store pulse", n_st, 1);
      chk(n_off == ST_CYC, "R7 store off length", n_off, ST_CYC);
      chk(n_rc == 0, "R7 reads ignored while off", n_rc, 0);
      chk(n_clr + n_xfer == 0, "R9 no phases on save", n_clr + n_xfer, 0);

      // R3 and R9: restore with two phases
      mon_clear();
      seq6(13'h0F0E);
      chk(recall_req && !store_req && clr_phase, "R3 recall pulse", {store_req, recall_req, clr_phase}, 3'b011);
      idle(20);
      chk(n_rc == 1, "R3 single recall pulse", n_rc, 1);
      chk(n_clr == CL_CYC, "R9 clear length", n_clr, CL_CYC);
      chk(n_xfer == XF_CYC, "R9 transfer length", n_xfer, XF_CYC);
      chk(n_order == 0, "R9 phase order", n_order, 0);
      chk(n_off == CL_CYC + XF_CYC, "R7 restore off length", n_off, CL_CYC + XF_CYC);

      // R8: inhibited save suppressed, restore unaffected
      mon_clear();
      lv_inhibit = 1'b1;
      seq6(13'h0F0F);
      idle(20);
      chk(n_st == 0 && n_off == 0, "R8 save inhibited", n_st + n_off, 0);
      seq6(13'h0F0E);
      idle(20);
      chk(n_rc == 1, "R8 restore while inhibited", n_rc, 1);
      lv_inhibit = 1'b0;

      // R10: busy cycle discards progress
      mon_clear();
      cyc(0, 1, 13'h0000); cyc(0, 1, 13'h1555); cyc(0, 1, 13'h0AAA);
      @(negedge clk); busy_in = 1'b1; cyc_valid = 1'b0;
      @(negedge clk); busy_in = 1'b0;
      cyc(0, 1, 13'h1FFF); cyc(0, 1, 13'h10F0); cyc(0, 1, 13'h0F0F);
      idle(20);
      chk(n_st == 0, "R10 busy discards progress", n_st, 0);

      // R11: reset mid-run discards progress
      mon_clear();
      cyc(0, 1, 13'h0000); cyc(0, 1, 13'h1555); cyc(0, 1, 13'h0AAA);
      @(negedge clk); cyc_valid = 1'b0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      cyc(0, 1, 13'h1FFF); cyc(0, 1, 13'h10F0); cyc(0, 1, 13'h0F0F);
      idle(20);
      chk(n_st == 0, "R11 reset discards run", n_st, 0);

      // R1: key order matters (second and third keys swapped)
      mon_clear();
      cyc(0, 1, 13'h0000); cyc(0, 1, 13'h0AAA); cyc(0, 1, 13'h1555);
      cyc(0, 1, 13'h1FFF); cyc(0, 1, 13'h10F0); cyc(0, 1, 13'h0F0F);
      idle(20);
      chk(n_st == 0, "R1 order enforced", n_st, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule